// File: doc/BRIEF.md
# Signed Multiply-Accumulate Engine

This block is the multiply-accumulate engine of a small RISC core. It holds a 64-bit accumulator made of a high word and a low word. It accepts one 32-bit instruction word per handshake, together with two 32-bit register operands, and decodes the operation itself. Three operations feed a product into the accumulator: accumulate with a register operand, subtract with a register operand, and accumulate with a 16-bit immediate. A readout operation returns the low accumulator word and empties the accumulator. A load-high-immediate operation shares the readout opcode and returns its immediate shifted into the upper half of a word. Any other instruction word is accepted and dropped.

Product operations pass through a multiplier with two register stages. While a product is in flight the engine stalls by dropping `issue_ready`, so a readout issued straight after an accumulate is held until the new sum is in place. The controller has three states. `ST_IDLE` accepts any instruction. An accepted product operation moves `ST_IDLE` to `ST_MUL_A`, where the operands are latched. `ST_MUL_A` always moves to `ST_MUL_B`, where the product register is loaded. `ST_MUL_B` always returns to `ST_IDLE`, and on that edge the accumulator takes the new sum. Readout, load-high and dropped words leave the state at `ST_IDLE`.

Top module: `smac_unit`

## Requirements
- R1: Accumulate (bits 31:26 = 0x31, bits 3:0 = 0x1) adds the sign-extended 32-bit product of `opnd_a` and `opnd_b` to the 64-bit value {high, low} and writes the sum back to both words.
- R2: Subtract (bits 31:26 = 0x31, bits 3:0 = 0x2) takes the sign-extended 32-bit product away from {high, low} instead of adding it.
- R3: The product is the low 32 bits of the signed 32x32 multiply. It is sign-extended to 64 bits only after that cut, so an accumulate into an empty accumulator leaves the high word equal to copies of bit 31 of the low word.
- R4: Immediate accumulate (bits 31:26 = 0x13) multiplies `opnd_a` by bits 15:0 of the instruction, sign-extended, and adds the result like R1.
- R5: Readout (bits 31:26 = 0x06, bit 16 = 1) returns the current low word on `res_data` and sets both accumulator words to zero in the same operation.
- R6: Load-high-immediate (bits 31:26 = 0x06, bit 16 = 0) returns bits 15:0 of the instruction in `res_data[31:16]` with `res_data[15:0]` zero, and leaves the accumulator unchanged.
- R7: After a product operation is accepted, `issue_ready` is low for exactly two cycles. A readout issued right after it waits and then returns the updated sum.
- R8: An instruction word with any other major opcode, or with opcode 0x31 and bits 3:0 other than 0x1 and 0x2, is accepted, produces no result and leaves the accumulator unchanged.
- R9: A synchronous active-high `rst` clears both accumulator words, raises `issue_ready` and lowers `res_valid`.
- R10: `res_valid` is high for exactly the cycle after each accepted readout or load-high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word and operands are presented |
| issue_ready | output | 1 | Engine can take an instruction this cycle |
| instr_word | input | 32 | Instruction word to decode |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| res_valid | output | 1 | `res_data` holds a new result |
| res_data | output | 32 | Readout or load-high result |

## Verification
The bench goes after products whose full value overflows 32 bits, such as 0x7FFFFFFF times 2 and 0x10000 squared. A design that sign-extends the full 64-bit product would leave a wrong high word, and the bound checker catches this after an accumulate into a cleared accumulator. Readout is issued on the first legal cycle after an accumulate. A design that forwards too little or stalls for too short a time returns the stale sum. Back-to-back readouts and a load-high placed between accumulates show whether clearing and non-disturbance are right: a readout that fails to clear gives a nonzero second result. Sub-op values 0x0 and 0x3 under opcode 0x31, together with an unrelated opcode, catch a decoder that treats near-misses as accumulates or emits a spurious result.

// File: rtl/smac_pkg.sv
`timescale 1ns/1ps
package smac_pkg;

    localparam int INSTR_W = 32;

    // Major opcode and sub-op codes; their bit positions are fixed by the core's decode.
    localparam logic [5:0] MAJ_MAC_REG = 6'h31;
    localparam logic [5:0] MAJ_MAC_IMM = 6'h13;
    localparam logic [5:0] MAJ_HI_RD   = 6'h06;
    localparam logic [3:0] SUB_ADD     = 4'h1;
    localparam logic [3:0] SUB_SUB     = 4'h2;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_MAC,
        OP_MSB,
        OP_MACI,
        OP_READ,
        OP_LDHI
    } mac_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL_A,
        ST_MUL_B
    } mac_state_e;

endpackage

// File: rtl/smac_decode.sv
`timescale 1ns/1ps
module smac_decode
    import smac_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic [INSTR_W-1:0] instr,
    output mac_op_e            op,
    output logic [IMM_W-1:0]   imm
);

    logic unused_instr_bits;
    assign unused_instr_bits = ^instr[25:17];

    assign imm = instr[IMM_W-1:0];

    always_comb begin
        op = OP_NONE;
        unique case (instr[31:26])
            MAJ_MAC_REG: begin
                if (instr[3:0] == SUB_ADD)
                    op = OP_MAC;
                else if (instr[3:0] == SUB_SUB)
                    op = OP_MSB;
            end
            MAJ_MAC_IMM: op = OP_MACI;
            MAJ_HI_RD:   op = instr[16] ? OP_READ : OP_LDHI;
            default:     op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/smac_mult.sv
`timescale 1ns/1ps
module smac_mult #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              load,
    input  logic [DATA_W-1:0] mul_a,
    input  logic [DATA_W-1:0] mul_b,
    output logic [DATA_W-1:0] prod
);

    // Stage one: operand capture. Stage two: truncated product.
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic [DATA_W-1:0] prod_q;

    always_ff @(posedge clk) begin
        if (load) begin
            a_q <= mul_a;
            b_q <= mul_b;
        end
        prod_q <= a_q * b_q;
    end

    assign prod = prod_q;

endmodule

// File: rtl/smac_accum.sv
`timescale 1ns/1ps
module smac_accum #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              subtract,
    input  logic              clear,
    input  logic [DATA_W-1:0] prod,
    output logic [DATA_W-1:0] acc_hi,
    output logic [DATA_W-1:0] acc_lo
);

    localparam int ACC_W = 2 * DATA_W;

    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] lo_q;
    logic [ACC_W-1:0]  cur;
    logic [ACC_W-1:0]  ext;
    logic [ACC_W-1:0]  nxt;

    assign cur = {hi_q, lo_q};
    assign ext = {{DATA_W{prod[DATA_W-1]}}, prod};
    assign nxt = subtract ? (cur - ext) : (cur + ext);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (commit) begin
            hi_q <= nxt[ACC_W-1:DATA_W];
            lo_q <= nxt[DATA_W-1:0];
        end
    end

    assign acc_hi = hi_q;
    assign acc_lo = lo_q;

endmodule

// File: rtl/smac_unit.sv
`timescale 1ns/1ps
module smac_unit
    import smac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_valid,
    output logic               issue_ready,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    output logic               res_valid,
    output logic [DATA_W-1:0]  res_data
);

    localparam int PAD_W = DATA_W - IMM_W;

    mac_state_e        state_q;
    mac_state_e        state_d;
    mac_op_e           dec_op;
    logic [IMM_W-1:0]  dec_imm;
    logic              accept;
    logic              is_prod_op;
    logic              mul_load;
    logic              commit;
    logic              clear;
    logic              sub_q;
    logic [DATA_W-1:0] mul_b_sel;
    logic [DATA_W-1:0] prod;
    logic [DATA_W-1:0] acc_hi;
    logic [DATA_W-1:0] acc_lo;

    smac_decode #(.IMM_W(IMM_W)) u_dec (
        .instr (instr_word),
        .op    (dec_op),
        .imm   (dec_imm)
    );

    assign is_prod_op = (dec_op == OP_MAC) || (dec_op == OP_MSB) || (dec_op == OP_MACI);
    assign mul_b_sel  = (dec_op == OP_MACI) ? {{PAD_W{dec_imm[IMM_W-1]}}, dec_imm} : opnd_b;

    smac_mult #(.DATA_W(DATA_W)) u_mul (
        .clk   (clk),
        .load  (mul_load),
        .mul_a (opnd_a),
        .mul_b (mul_b_sel),
        .prod  (prod)
    );

    smac_accum #(.DATA_W(DATA_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .subtract (sub_q),
        .clear    (clear),
        .prod     (prod),
        .acc_hi   (acc_hi),
        .acc_lo   (acc_lo)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && is_prod_op) state_d = ST_MUL_A;
            ST_MUL_A: state_d = ST_MUL_B;
            ST_MUL_B: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and control strobes
    always_comb begin
        issue_ready = 1'b0;
        commit      = 1'b0;
        unique case (state_q)
            ST_IDLE:  issue_ready = 1'b1;
            ST_MUL_A: issue_ready = 1'b0;
            ST_MUL_B: commit      = 1'b1;
            default:  issue_ready = 1'b0;
        endcase
        accept   = issue_valid && issue_ready;
        mul_load = accept && is_prod_op;
        clear    = accept && (dec_op == OP_READ);
    end

    // Registered result and subtract mode
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            sub_q     <= 1'b0;
        end else begin
            res_valid <= accept && ((dec_op == OP_READ) || (dec_op == OP_LDHI));
            if (accept && dec_op == OP_READ)
                res_data <= acc_lo;
            else if (accept && dec_op == OP_LDHI)
                res_data <= {dec_imm, {PAD_W{1'b0}}};
            if (mul_load)
                sub_q <= (dec_op == OP_MSB);
        end
    end

endmodule

// File: rtl/smac_unit_chk.sv
`timescale 1ns/1ps
module smac_unit_chk
    import smac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_valid,
    input logic              issue_ready,
    input mac_op_e           dec_op,
    input logic [IMM_W-1:0]  ldhi_imm,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [DATA_W-1:0] acc_hi,
    input logic [DATA_W-1:0] acc_lo,
    input logic              commit,
    input logic              sub_q
);

    logic took;
    assign took = issue_valid && issue_ready;

    assert_sext_R3: assert property (@(posedge clk) disable iff (rst)
        (commit && !sub_q && acc_hi == '0 && acc_lo == '0)
        |=> (acc_hi == {DATA_W{acc_lo[DATA_W-1]}}));

    assert_read_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (took && dec_op == OP_READ)
        |=> (acc_hi == '0 && acc_lo == '0 && res_data == $past(acc_lo)));

    assert_ldhi_R6: assert property (@(posedge clk) disable iff (rst)
        (took && dec_op == OP_LDHI)
        |=> (res_data == {$past(ldhi_imm), {(DATA_W-IMM_W){1'b0}}}
             && $stable(acc_hi) && $stable(acc_lo)));

    assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (took && (dec_op == OP_MAC || dec_op == OP_MSB || dec_op == OP_MACI))
        |=> !issue_ready);

    assert_busy_two_R7: assert property (@(posedge clk) disable iff (rst)
        (!issue_ready && $past(!issue_ready)) |=> issue_ready);

    assert_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (took && dec_op == OP_NONE)
        |=> ($stable(acc_hi) && $stable(acc_lo)));

    assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        !(took && (dec_op == OP_READ || dec_op == OP_LDHI)) |=> !res_valid);

endmodule

bind smac_unit smac_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .dec_op      (dec_op),
    .ldhi_imm    (instr_word[IMM_W-1:0]),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .acc_hi      (acc_hi),
    .acc_lo      (acc_lo),
    .commit      (commit),
    .sub_q       (sub_q)
);

// File: tb/smac_unit_tb.sv
`timescale 1ns/1ps
module smac_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [31:0] instr_word = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        res_valid;
    logic [31:0] res_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit summary_done = 1'b0;

    logic [63:0] model_acc = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    smac_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .issue_ready (issue_ready),
        .instr_word  (instr_word),
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .res_valid   (res_valid),
        .res_data    (res_data)
    );

    function automatic [31:0] w_mac(input logic [3:0] sub);
        return {6'h31, 22'h0, sub};
    endfunction
    function automatic [31:0] w_maci(input logic [15:0] imm);
        return {6'h13, 10'h0, imm};
    endfunction
    function automatic [31:0] w_hi(input logic rd, input logic [15:0] imm);
        return {6'h06, 9'h0, rd, imm};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // Driver: wait for ready at a falling edge, present for one rising edge.
    task automatic drive(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        while (!issue_ready) @(negedge clk);
        instr_word  = w;
        opnd_a      = a;
        opnd_b      = b;
        issue_valid = 1'b1;
        @(posedge clk);
        #1 issue_valid = 1'b0;
    endtask

    task automatic do_mac(input logic [31:0] a, input logic [31:0] b, input bit sub);
        logic [31:0] p;
        p = a * b;
        drive(w_mac(sub ? 4'h2 : 4'h1), a, b);
        if (sub) model_acc = model_acc - {{32{p[31]}}, p};
        else     model_acc = model_acc + {{32{p[31]}}, p};
    endtask

    task automatic do_maci(input logic [31:0] a, input logic [15:0] imm);
        logic [31:0] p;
        p = a * {{16{imm[15]}}, imm};
        drive(w_maci(imm), a, 32'h5A5A_5A5A);
        model_acc = model_acc + {{32{p[31]}}, p};
    endtask

    task automatic do_read(input string tag);
        exp_q.push_back(model_acc[31:0]);
        tag_q.push_back(tag);
        model_acc = '0;
        drive(w_hi(1'b1, 16'h0), 32'h0, 32'h0);
    endtask

    task automatic do_ldhi(input logic [15:0] imm, input string tag);
        exp_q.push_back({imm, 16'h0});
        tag_q.push_back(tag);
        drive(w_hi(1'b0, imm), 32'h1234_5678, 32'h0);
    endtask

    // Monitor: every result is popped from the scoreboard and compared.
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected result", res_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(res_data === e, t, res_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h0);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(issue_ready === 1'b1, "R9 ready after reset", {31'h0, issue_ready}, 32'h1);
        check(res_valid === 1'b0, "R9 no result after reset", {31'h0, res_valid}, 32'h0);
        do_read("R9 accumulator zero after reset");

        // R1: add products, including a negative one
        do_mac(32'd3, 32'd4, 1'b0);
        do_mac(-32'sd5, 32'd7, 1'b0);
        do_read("R1 accumulate");
        do_read("R5 second readout sees cleared word");

        // R2: subtract
        do_mac(32'd100, 32'd100, 1'b0);
        do_mac(32'd30, 32'd3, 1'b1);
        do_mac(32'hFFFF_FFFF, 32'd9, 1'b1);
        do_read("R2 subtract");

        // R3: products that overflow 32 bits
        do_mac(32'h0001_0000, 32'h0001_0000, 1'b0);
        do_mac(32'h7FFF_FFFF, 32'd2, 1'b0);
        do_read("R3 truncated product");
        do_mac(32'h8000_0001, 32'h8000_0001, 1'b0);
        do_mac(32'd7, 32'd1, 1'b1);
        do_read("R3 wrapped signed product");

        // R4: immediate form, negative and positive immediates
        do_maci(32'd1000, 16'hFFFE);
        do_maci(-32'sd3, 16'h7FFF);
        do_read("R4 immediate accumulate");

        // R6: load-high between accumulates leaves the sum alone
        do_mac(32'd5, 32'd5, 1'b0);
        do_ldhi(16'hABCD, "R6 load-high value");
        do_mac(32'd2, 32'd2, 1'b0);
        do_ldhi(16'h8001, "R6 load-high top bit");
        do_read("R6 accumulator untouched by load-high");

        // R8: near-miss and foreign instruction words are dropped
        do_mac(32'd2, 32'd3, 1'b0);
        drive({6'h31, 22'h0, 4'h3}, 32'd7, 32'd7);
        drive({6'h31, 22'h0, 4'h0}, 32'd9, 32'd9);
        drive({6'h27, 26'h3FF_FFFF}, 32'd11, 32'd11);
        do_read("R8 ignored words");

        // R7: stall window and readout right after accumulate
        drive(w_mac(4'h1), 32'd6, 32'd7);
        model_acc = model_acc + 64'd42;
        @(negedge clk);
        check(issue_ready === 1'b0, "R7 busy cycle 1", {31'h0, issue_ready}, 32'h0);
        @(negedge clk);
        check(issue_ready === 1'b0, "R7 busy cycle 2", {31'h0, issue_ready}, 32'h0);
        #0;
        exp_q.push_back(model_acc[31:0]);
        tag_q.push_back("R7 readout after stall");
        model_acc = '0;
        @(negedge clk);
        check(issue_ready === 1'b1, "R7 ready again", {31'h0, issue_ready}, 32'h1);
        instr_word  = w_hi(1'b1, 16'h0);
        issue_valid = 1'b1;
        @(posedge clk);
        #1 issue_valid = 1'b0;
        @(negedge clk);
        check(res_valid === 1'b1, "R10 pulse high", {31'h0, res_valid}, 32'h1);
        @(negedge clk);
        check(res_valid === 1'b0, "R10 pulse low", {31'h0, res_valid}, 32'h0);

        // R10: back-to-back results
        do_ldhi(16'h0F0F, "R10 first of pair");
        do_ldhi(16'hF0F0, "R10 second of pair");

        // R9: reset in the middle of a sum
        do_mac(32'd123, 32'd456, 1'b0);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_acc = '0;
        do_read("R9 reset clears accumulator");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 missing results", exp_q.size(), 32'h0);
        summary();
    end

endmodule